// File: doc/BRIEF.md
# Limited-Range Pixel Clamp

This block sits in a display output path and forces every colour component of an RGB pixel stream into a limited (studio) range before the pixel leaves the chip. Components are carried as 12-bit values aligned to the most significant bit. Narrower source depths are therefore compared against limits that are shifted up to the 12-bit scale.

A 3-bit format code picks the limits. The code can select one of three preset ranges, for 8-bit, 10-bit and 12-bit content. It can also select a programmable mode, in which each of R, G and B has its own lower and upper bound taken from input ports. Clamping happens only when the enable input is high and the code names a limited range. In every other case the pixel passes through unchanged. The result leaves a single register stage one cycle after it enters, and the valid flag travels with it.

Top module: `pix_range_clamp`

## Requirements
- R1: While rst_n is low at a rising edge, out_valid, out_r, out_g and out_b are all cleared to zero.
- R2: out_valid equals in_valid of the previous cycle. When in_valid is high, the processed components appear on out_r/out_g/out_b one cycle later.
- R3: When in_valid is low, out_r, out_g and out_b keep their previous values whatever the data inputs carry.
- R4: When clamp_en is low, every component passes through unchanged for every format code.
- R5: Format code 0 (full range) passes every component through unchanged even with clamp_en high.
- R6: Format code 1 applies the 8-bit limits 16 and 235, shifted left by 4 bits: 256 to 3760 on the 12-bit scale.
- R7: Format code 2 applies the 10-bit limits 64 and 940, shifted left by 2 bits: 256 to 3760 on the 12-bit scale.
- R8: Format code 3 applies the 12-bit limits 256 to 3760.
- R9: Format code 7 applies lo_r/hi_r to R, lo_g/hi_g to G and lo_b/hi_b to B, each channel independently of the others.
- R10: Unlisted format codes 4, 5 and 6 pass every component through unchanged.
- R11: A component below the lower bound becomes the lower bound, and one above the upper bound becomes the upper bound. Values equal to either bound, or between the bounds, are unchanged.
- R12: In the programmable mode, if a lower bound exceeds its upper bound, the lower test takes priority. Values below the lower bound become the lower bound, and all other values become the upper bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 12 | Red component in |
| in_g | input | 12 | Green component in |
| in_b | input | 12 | Blue component in |
| clamp_en | input | 1 | Clamp enable |
| fmt_code | input | 3 | Range format: 0 full, 1 8-bit, 2 10-bit, 3 12-bit, 7 programmable |
| lo_r | input | 12 | Programmable lower bound, red |
| hi_r | input | 12 | Programmable upper bound, red |
| lo_g | input | 12 | Programmable lower bound, green |
| hi_g | input | 12 | Programmable upper bound, green |
| lo_b | input | 12 | Programmable lower bound, blue |
| hi_b | input | 12 | Programmable upper bound, blue |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 12 | Red component out |
| out_g | output | 12 | Green component out |
| out_b | output | 12 | Blue component out |

## Verification
Directed pixels land exactly on each preset bound and one step to either side of it, and also at 0 and full scale. These show whether the comparisons include the bound and whether each preset is shifted correctly. In random traffic all eight format codes are mixed with enable toggling and idle cycles, so pass-through, hold and clamping are checked against each other. In programmable mode the three channels get unrelated bounds, so a swapped channel shows up. Some cases use an inverted bound pair to fix the priority between the two comparisons.

// File: rtl/clamp_pkg.sv
// Package: shared format codes and preset-limit helpers for the pixel clamp.
// Assumes components are MSB-aligned and at least 12 bits wide.
package clamp_pkg;

    localparam int NCH = 3;

    // Range selection codes carried on fmt_code.
    typedef enum logic [2:0] {
        FMT_FULL  = 3'd0,
        FMT_LIM8  = 3'd1,
        FMT_LIM10 = 3'd2,
        FMT_LIM12 = 3'd3,
        FMT_PROG  = 3'd7
    } fmt_code_e;

    // Scale a limit given at src_bits depth up to a w-bit MSB-aligned value.
    function automatic int scale_limit(input int value, input int src_bits, input int w);
        return value << (w - src_bits);
    endfunction

endpackage

// File: rtl/clamp_limit_sel.sv
// Module: decodes enable and format code into an active flag and per-channel
// lower/upper bounds. Purely combinational; assumes W >= 12.
module clamp_limit_sel
    import clamp_pkg::*;
#(
    parameter int W = 12,
    parameter int N = NCH
) (
    input  logic                 clamp_en,
    input  logic [2:0]           fmt_code,
    input  logic [N-1:0][W-1:0]  prog_lo,
    input  logic [N-1:0][W-1:0]  prog_hi,
    output logic                 active,
    output logic [N-1:0][W-1:0]  lim_lo,
    output logic [N-1:0][W-1:0]  lim_hi
);

    localparam logic [W-1:0] L8_LO  = W'(scale_limit(16, 8, W));
    localparam logic [W-1:0] L8_HI  = W'(scale_limit(235, 8, W));
    localparam logic [W-1:0] L10_LO = W'(scale_limit(64, 10, W));
    localparam logic [W-1:0] L10_HI = W'(scale_limit(940, 10, W));
    localparam logic [W-1:0] L12_LO = W'(scale_limit(256, 12, W));
    localparam logic [W-1:0] L12_HI = W'(scale_limit(3760, 12, W));

    // Pick limits per channel from the preset table or programmed bounds.
    always_comb begin
        active = 1'b0;
        lim_lo = '0;
        lim_hi = '0;
        if (clamp_en) begin
            case (fmt_code)
                FMT_LIM8: begin
                    active = 1'b1;
                    for (int c = 0; c < N; c++) begin
                        lim_lo[c] = L8_LO;
                        lim_hi[c] = L8_HI;
                    end
                end
                FMT_LIM10: begin
                    active = 1'b1;
                    for (int c = 0; c < N; c++) begin
                        lim_lo[c] = L10_LO;
                        lim_hi[c] = L10_HI;
                    end
                end
                FMT_LIM12: begin
                    active = 1'b1;
                    for (int c = 0; c < N; c++) begin
                        lim_lo[c] = L12_LO;
                        lim_hi[c] = L12_HI;
                    end
                end
                FMT_PROG: begin
                    active = 1'b1;
                    lim_lo = prog_lo;
                    lim_hi = prog_hi;
                end
                default: active = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/clamp_lane.sv
// Module: clamps one component against a lower and upper bound.
// The lower test has priority when the bounds are inverted. Combinational.
module clamp_lane #(
    parameter int W = 12
) (
    input  logic         active,
    input  logic [W-1:0] x,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic [W-1:0] y
);

    logic below;
    logic above;

    // Compare the component against both bounds.
    always_comb begin
        below = x < lo;
        above = x > hi;
    end

    // Select lower bound, upper bound or the unchanged component.
    always_comb begin
        if (!active)     y = x;
        else if (below)  y = lo;
        else if (above)  y = hi;
        else             y = x;
    end

endmodule

// File: rtl/clamp_out_stage.sv
// Module: single output register stage; captures data only on valid and
// pipes the valid flag. Synchronous active-low reset clears everything.
module clamp_out_stage #(
    parameter int W = 12,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                d_valid,
    input  logic [N-1:0][W-1:0] d,
    output logic                q_valid,
    output logic [N-1:0][W-1:0] q
);

    // Pipe the valid flag by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= d_valid;
    end

    // Capture clamped data only for valid pixels, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (d_valid) q <= d;
    end

endmodule

// File: rtl/pix_range_clamp.sv
// Module: limited-range pixel clamp top. Decodes the range, clamps the three
// components in parallel lanes and registers the result (latency 1).
// Assumes MSB-aligned components of width W >= 12.
module pix_range_clamp
    import clamp_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_r,
    input  logic [W-1:0] in_g,
    input  logic [W-1:0] in_b,
    input  logic         clamp_en,
    input  logic [2:0]   fmt_code,
    input  logic [W-1:0] lo_r,
    input  logic [W-1:0] hi_r,
    input  logic [W-1:0] lo_g,
    input  logic [W-1:0] hi_g,
    input  logic [W-1:0] lo_b,
    input  logic [W-1:0] hi_b,
    output logic         out_valid,
    output logic [W-1:0] out_r,
    output logic [W-1:0] out_g,
    output logic [W-1:0] out_b
);

    logic [NCH-1:0][W-1:0] pix_in;
    logic [NCH-1:0][W-1:0] prog_lo;
    logic [NCH-1:0][W-1:0] prog_hi;
    logic [NCH-1:0][W-1:0] lim_lo;
    logic [NCH-1:0][W-1:0] lim_hi;
    logic [NCH-1:0][W-1:0] pix_clamped;
    logic [NCH-1:0][W-1:0] pix_out;
    logic                  active;

    // Gather channel ports into arrays (index 0 = R, 1 = G, 2 = B).
    always_comb begin
        pix_in  = {in_b, in_g, in_r};
        prog_lo = {lo_b, lo_g, lo_r};
        prog_hi = {hi_b, hi_g, hi_r};
    end

    clamp_limit_sel #(.W(W), .N(NCH)) u_sel (
        .clamp_en (clamp_en),
        .fmt_code (fmt_code),
        .prog_lo  (prog_lo),
        .prog_hi  (prog_hi),
        .active   (active),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        clamp_lane #(.W(W)) u_lane (
            .active (active),
            .x      (pix_in[c]),
            .lo     (lim_lo[c]),
            .hi     (lim_hi[c]),
            .y      (pix_clamped[c])
        );
    end

    clamp_out_stage #(.W(W), .N(NCH)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_valid (in_valid),
        .d       (pix_clamped),
        .q_valid (out_valid),
        .q       (pix_out)
    );

    // Split the registered array back onto the channel ports.
    always_comb begin
        out_r = pix_out[0];
        out_g = pix_out[1];
        out_b = pix_out[2];
    end

endmodule

// File: rtl/pix_range_clamp_checks.sv
// Checker: port-level temporal properties of the pixel clamp, bound to the top.
module pix_range_clamp_checks #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_r,
    input logic [W-1:0] in_g,
    input logic [W-1:0] in_b,
    input logic         clamp_en,
    input logic [2:0]   fmt_code,
    input logic [W-1:0] lo_r,
    input logic [W-1:0] hi_r,
    input logic         out_valid,
    input logic [W-1:0] out_r,
    input logic [W-1:0] out_g,
    input logic [W-1:0] out_b
);

    localparam logic [W-1:0] PRE_LO = W'(256 << (W - 12));
    localparam logic [W-1:0] PRE_HI = W'(3760 << (W - 12));

    assert_reset_clear_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));

    assert_bypass_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(clamp_en))
        |-> (out_r == $past(in_r) && out_g == $past(in_g) && out_b == $past(in_b)));

    assert_preset_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(clamp_en)
         && ($past(fmt_code) == 3'd1 || $past(fmt_code) == 3'd2 || $past(fmt_code) == 3'd3))
        |-> (out_r >= PRE_LO && out_r <= PRE_HI && out_g >= PRE_LO && out_g <= PRE_HI
             && out_b >= PRE_LO && out_b <= PRE_HI));

    assert_prog_red_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(clamp_en) && $past(fmt_code) == 3'd7
         && $past(lo_r) <= $past(hi_r))
        |-> (out_r >= $past(lo_r) && out_r <= $past(hi_r)));

endmodule

bind pix_range_clamp pix_range_clamp_checks #(.W(W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_r      (in_r),
    .in_g      (in_g),
    .in_b      (in_b),
    .clamp_en  (clamp_en),
    .fmt_code  (fmt_code),
    .lo_r      (lo_r),
    .hi_r      (hi_r),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/pix_range_clamp_test.sv
// Bench: directed corners plus seeded random traffic, checked against a
// reference function written from the requirements.
module pix_range_clamp_test;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_r = '0, in_g = '0, in_b = '0;
    logic         clamp_en = 1'b0;
    logic [2:0]   fmt_code = '0;
    logic [W-1:0] lo_r = '0, hi_r = '0, lo_g = '0, hi_g = '0, lo_b = '0, hi_b = '0;
    logic         out_valid;
    logic [W-1:0] out_r, out_g, out_b;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pix_range_clamp #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .clamp_en(clamp_en), .fmt_code(fmt_code),
        .lo_r(lo_r), .hi_r(hi_r), .lo_g(lo_g), .hi_g(hi_g), .lo_b(lo_b), .hi_b(hi_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // Reference: expected component from the requirements.
    function automatic logic [W-1:0] ref_clamp(input logic [W-1:0] x, input logic en,
                                               input logic [2:0] code,
                                               input logic [W-1:0] plo, input logic [W-1:0] phi);
        int lo, hi;
        if (!en) return x;
        case (code)
            3'd1: begin lo = 16 * 16; hi = 235 * 16; end
            3'd2: begin lo = 64 * 4;  hi = 940 * 4;  end
            3'd3: begin lo = 256;     hi = 3760;     end
            3'd7: begin lo = int'(plo); hi = int'(phi); end
            default: return x;
        endcase
        if (int'(x) < lo) return W'(lo);
        if (int'(x) > hi) return W'(hi);
        return x;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one valid pixel, then check outputs one cycle later.
    task automatic send(input string req, input logic en, input logic [2:0] code,
                        input logic [W-1:0] r, input logic [W-1:0] g, input logic [W-1:0] b);
        logic [W-1:0] er, eg, eb;
        @(negedge clk);
        in_valid = 1'b1; clamp_en = en; fmt_code = code;
        in_r = r; in_g = g; in_b = b;
        er = ref_clamp(r, en, code, lo_r, hi_r);
        eg = ref_clamp(g, en, code, lo_g, hi_g);
        eb = ref_clamp(b, en, code, lo_b, hi_b);
        @(posedge clk); #1;
        check({req, " valid"}, W'(out_valid), W'(1));
        check({req, " r"}, out_r, er);
        check({req, " g"}, out_g, eg);
        check({req, " b"}, out_b, eb);
    endtask

    // Drive an idle cycle with junk data; outputs must hold.
    task automatic idle_check(input logic [W-1:0] junk);
        logic [W-1:0] pr, pg, pb;
        @(negedge clk);
        pr = out_r; pg = out_g; pb = out_b;
        in_valid = 1'b0; clamp_en = 1'b1; fmt_code = 3'd3;
        in_r = junk; in_g = ~junk; in_b = junk ^ 12'h5A5;
        @(posedge clk); #1;
        check("R2 idle valid", W'(out_valid), W'(0));
        check("R3 hold r", out_r, pr);
        check("R3 hold g", out_g, pg);
        check("R3 hold b", out_b, pb);
    endtask

    initial begin : watchdog
        #2ms;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        in_r = 12'hABC; in_g = 12'h123; in_b = 12'hFFF; in_valid = 1'b1; clamp_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", W'(out_valid), W'(0));
        check("R1 reset r", out_r, '0);
        check("R1 reset g", out_g, '0);
        check("R1 reset b", out_b, '0);
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;

        // R4: enable low, every code passes through
        for (int c = 0; c < 8; c++) send("R4", 1'b0, 3'(c), 12'd0, 12'd4095, 12'd100);
        send("R5", 1'b1, 3'd0, 12'd0, 12'd4095, 12'd255);
        // R6/R7/R8 with bound +/-1 to exercise R11 edges
        send("R6", 1'b1, 3'd1, 12'd255, 12'd256, 12'd3761);
        send("R6", 1'b1, 3'd1, 12'd3760, 12'd257, 12'd0);
        send("R7", 1'b1, 3'd2, 12'd4095, 12'd3759, 12'd255);
        send("R8", 1'b1, 3'd3, 12'd256, 12'd3760, 12'd3761);
        send("R11", 1'b1, 3'd3, 12'd0, 12'd4095, 12'd2000);
        // R10: unlisted codes are pass-through
        send("R10", 1'b1, 3'd4, 12'd0, 12'd4095, 12'd1);
        send("R10", 1'b1, 3'd5, 12'd4000, 12'd4095, 12'd10);
        send("R10", 1'b1, 3'd6, 12'd3, 12'd4094, 12'd200);
        // R9: independent per-channel bounds
        lo_r = 12'h010; hi_r = 12'hFEF;
        lo_g = 12'd1000; hi_g = 12'd2000;
        lo_b = 12'd50;  hi_b = 12'd60;
        send("R9", 1'b1, 3'd7, 12'h00F, 12'd999, 12'd61);
        send("R9", 1'b1, 3'd7, 12'hFF0, 12'd2001, 12'd49);
        send("R11", 1'b1, 3'd7, 12'h010, 12'd2000, 12'd50);
        // R12: inverted bounds
        lo_g = 12'd3000; hi_g = 12'd1000;
        send("R12", 1'b1, 3'd7, 12'd500, 12'd2999, 12'd55);
        send("R12", 1'b1, 3'd7, 12'd500, 12'd3500, 12'd55);
        idle_check(12'h777);
        idle_check(12'h001);

        // Random mix: codes, enable, bounds and idle cycles
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 8) == 0) begin
                idle_check(W'($urandom));
            end else begin
                logic [2:0] code;
                if (($urandom % 16) == 0) begin
                    lo_r = W'($urandom); hi_r = W'($urandom);
                    lo_g = W'($urandom); hi_g = W'($urandom);
                    lo_b = W'($urandom); hi_b = W'($urandom);
                end
                code = 3'($urandom);
                send(code == 3'd7 ? "R9" : (code == 3'd0 ? "R5" : (code > 3'd3 ? "R10" : "R11")),
                     ($urandom % 4) != 0, code,
                     W'($urandom), W'($urandom), W'($urandom));
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule